// File: doc/BRIEF.md
# Signature Compressor with Per-Stage Inversion

This block is a k-stage internal-feedback signature register. On each accepted clock it folds one k-bit test response word into its state. It differs from a plain polynomial signature register in one way. The link out of every stage can carry either the true or the complemented value of that stage, and the feedback into the first stage can carry one extra inversion. Each of these choices is fixed by a parameter bit. The link and feedback inversions are chosen offline. They let the register start from any convenient seed and still land on any convenient final signature. A common choice is zero for both, which removes both the seed reload and the stored reference value.

A test controller pulses a start input to open a session. It then presents the response words with an enable, one word per enabled clock, for a fixed count of words. A parameter can add one padding step with an all-zero word after the last response. This padding step makes a target signature reachable when the plain word count cannot reach it. When the session ends, the block pulses done for one cycle and raises a pass flag if the signature equals the expected constant. The register keeps its contents after the session. The next session compresses on top of those contents, so a signature equal to the seed serves as the next seed with no reload.

Top module: `misr_mixed`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, sig_o equals SEED, done_o is 0 and pass_o is 0.
- R2: Each enabled word during a session updates the state as follows. Let v = state XOR LINK_INV and fb = v[WIDTH-1] XOR FB_INV. Then next[0] = fb XOR rsp_i[0]. For j >= 1, next[j] = v[j-1] XOR (fb AND TAPS[j]) XOR rsp_i[j]. TAPS holds the feedback polynomial coefficients of X^0 to X^(WIDTH-1), and bit 0 must be 1. The result appears on sig_o in the cycle after the edge.
- R3: During a session, a clock with en_i low leaves sig_o unchanged, whatever rsp_i carries.
- R4: done_o is high for exactly one cycle. That cycle follows the edge of the final step. The final step is the LEN-th enabled word when PAD_EN is 0, or the padding step when PAD_EN is 1.
- R5: With PAD_EN set, the clock after the LEN-th word performs one more step as in R2 with an all-zero word. This step does not need en_i and ignores rsp_i.
- R6: In the done_o cycle, pass_o is 1 exactly when sig_o equals GOLDEN. pass_o then holds its value until the next accepted start.
- R7: Outside a session, sig_o does not change, whatever en_i and rsp_i carry. A start pulse during a session has no effect.
- R8: An accepted start does not reload the register. The first step of a session applies R2 to the contents left by the previous session, or to SEED after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low clear, loads SEED |
| start_i | input | 1 | Opens a session when idle |
| en_i | input | 1 | Marks rsp_i as a valid response word |
| rsp_i | input | WIDTH | Response word, bit p feeds stage p |
| sig_o | output | WIDTH | True outputs of the stages (signature) |
| done_o | output | 1 | One-cycle pulse after the final step |
| pass_o | output | 1 | Signature matched GOLDEN at the end of the last session |

## Verification
The bound checker watches several behaviours on every cycle. It confirms that done_o is a single-cycle pulse, that done_o comes only after exactly LEN enabled words, and that the register stays frozen outside a session. It also checks that pass_o rises only with done_o and then matches the comparison of sig_o against GOLDEN. The bench scenarios show the rest. These are the bit-exact step equation with its inversions, freezing on idle enable cycles within a session, the zero padding step that ignores the input, a run built to reach the zero signature, and the next session carrying on from the held contents.

// File: rtl/misr_mixed_pkg.sv
package misr_mixed_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_PAD  = 2'd2
    } misr_phase_e;

endpackage

// File: rtl/misr_mixed_step.sv
// One compression step of the register: fixed link and feedback
// inversions, internal feedback taps, and the response word folded in.
module misr_mixed_step #(
    parameter int               WIDTH    = 8,
    parameter logic [WIDTH-1:0] TAPS     = 8'h1D,
    parameter logic [WIDTH-1:0] LINK_INV = 8'h00,
    parameter logic             FB_INV   = 1'b0
) (
    input  logic [WIDTH-1:0] cur_i,
    input  logic [WIDTH-1:0] word_i,
    output logic [WIDTH-1:0] nxt_o
);

    logic [WIDTH-1:0] link;
    logic             fb;

    // value leaving each stage: true or complemented output
    assign link = cur_i ^ LINK_INV;
    assign fb   = link[WIDTH-1] ^ FB_INV;

    for (genvar j = 0; j < WIDTH; j++) begin : g_stage
        if (j == 0) begin : g_first
            assign nxt_o[j] = fb ^ word_i[j];
        end else begin : g_rest
            assign nxt_o[j] = link[j-1] ^ (fb & TAPS[j]) ^ word_i[j];
        end
    end

endmodule

// File: rtl/misr_mixed_seq.sv
// Session sequencer: counts enabled words, adds the optional padding
// step and produces the end-of-session pulse.
module misr_mixed_seq
    import misr_mixed_pkg::*;
#(
    parameter int LEN    = 6,
    parameter bit PAD_EN = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic en_i,
    output logic go_o,
    output logic adv_o,
    output logic pad_o,
    output logic fin_o,
    output logic done_o
);

    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    typedef struct packed {
        misr_phase_e    phase;
        logic [CW-1:0]  cnt;
        logic           done;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        go_o       = 1'b0;
        adv_o      = 1'b0;
        pad_o      = 1'b0;
        fin_o      = 1'b0;
        unique case (seq_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    go_o        = 1'b1;
                    seq_d.phase = PH_RUN;
                    seq_d.cnt   = '0;
                end
            end
            PH_RUN: begin
                if (en_i) begin
                    adv_o = 1'b1;
                    if (seq_q.cnt == LAST) begin
                        if (PAD_EN) begin
                            seq_d.phase = PH_PAD;
                        end else begin
                            seq_d.phase = PH_IDLE;
                            seq_d.done  = 1'b1;
                            fin_o       = 1'b1;
                        end
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end
            end
            PH_PAD: begin
                adv_o       = 1'b1;
                pad_o       = 1'b1;
                fin_o       = 1'b1;
                seq_d.done  = 1'b1;
                seq_d.phase = PH_IDLE;
            end
            default: seq_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '{phase: PH_IDLE, cnt: '0, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign done_o = seq_q.done;

endmodule

// File: rtl/misr_mixed.sv
// Signature compressor with per-stage inversion, top level.
module misr_mixed #(
    parameter int               WIDTH    = 8,
    parameter logic [WIDTH-1:0] TAPS     = 8'h1D,
    parameter logic [WIDTH-1:0] LINK_INV = 8'hA5,
    parameter logic             FB_INV   = 1'b1,
    parameter logic [WIDTH-1:0] SEED     = '0,
    parameter logic [WIDTH-1:0] GOLDEN   = '0,
    parameter int               LEN      = 6,
    parameter bit               PAD_EN   = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             en_i,
    input  logic [WIDTH-1:0] rsp_i,
    output logic [WIDTH-1:0] sig_o,
    output logic             done_o,
    output logic             pass_o
);

    typedef struct packed {
        logic [WIDTH-1:0] sig;
        logic             pass;
    } reg_t;

    reg_t             st_d, st_q;
    logic             go, adv, pad, fin;
    logic [WIDTH-1:0] word, nxt;

    misr_mixed_seq #(
        .LEN    (LEN),
        .PAD_EN (PAD_EN)
    ) u_seq (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start_i),
        .en_i    (en_i),
        .go_o    (go),
        .adv_o   (adv),
        .pad_o   (pad),
        .fin_o   (fin),
        .done_o  (done_o)
    );

    assign word = pad ? '0 : rsp_i;

    misr_mixed_step #(
        .WIDTH    (WIDTH),
        .TAPS     (TAPS),
        .LINK_INV (LINK_INV),
        .FB_INV   (FB_INV)
    ) u_step (
        .cur_i  (st_q.sig),
        .word_i (word),
        .nxt_o  (nxt)
    );

    always_comb begin
        st_d = st_q;
        if (go) begin
            st_d.pass = 1'b0;
        end
        if (adv) begin
            st_d.sig = nxt;
        end
        if (fin) begin
            st_d.pass = (nxt == GOLDEN);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{sig: SEED, pass: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sig_o  = st_q.sig;
    assign pass_o = st_q.pass;

endmodule

// File: rtl/misr_mixed_chk.sv
module misr_mixed_chk #(
    parameter int               WIDTH  = 8,
    parameter logic [WIDTH-1:0] GOLDEN = '0,
    parameter int               LEN    = 6
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             start_i,
    input logic             en_i,
    input logic [WIDTH-1:0] sig_o,
    input logic             done_o,
    input logic             pass_o
);

    localparam int CW = $clog2(LEN + 1);

    logic          in_sess_q;
    logic [CW-1:0] words_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            in_sess_q <= 1'b0;
            words_q   <= '0;
        end else begin
            if (done_o) begin
                in_sess_q <= start_i;
            end else if (start_i) begin
                in_sess_q <= 1'b1;
            end
            if (start_i && (!in_sess_q || done_o)) begin
                words_q <= '0;
            end else if (in_sess_q && en_i && (words_q < CW'(LEN))) begin
                words_q <= words_q + 1'b1;
            end
        end
    end

    // R4
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R4
    done_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (words_q == CW'(LEN)));

    // R7
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_sess_q |=> $stable(sig_o));

    // R6
    pass_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pass_o) |-> done_o);

    // R6
    pass_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (pass_o == (sig_o == GOLDEN)));

endmodule

bind misr_mixed misr_mixed_chk #(
    .WIDTH  (WIDTH),
    .GOLDEN (GOLDEN),
    .LEN    (LEN)
) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .en_i    (en_i),
    .sig_o   (sig_o),
    .done_o  (done_o),
    .pass_o  (pass_o)
);

// File: tb/misr_mixed_tb.sv
module misr_mixed_tb;

    localparam int               W      = 8;
    localparam logic [W-1:0]     TAPS   = 8'h1D;
    localparam logic [W-1:0]     LINV   = 8'hA5;
    localparam logic             FINV   = 1'b1;
    localparam logic [W-1:0]     SEED   = 8'h00;
    localparam logic [W-1:0]     GOLDEN = 8'h00;
    localparam int               LEN    = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         en = 1'b0;
    logic [W-1:0] rsp = '0;
    logic [W-1:0] sig;
    logic         done, pass;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;
    logic [W-1:0] exp_sig;

    always #5 clk = ~clk;

    misr_mixed #(
        .WIDTH (W), .TAPS (TAPS), .LINK_INV (LINV), .FB_INV (FINV),
        .SEED (SEED), .GOLDEN (GOLDEN), .LEN (LEN), .PAD_EN (1'b1)
    ) u_dut (
        .clk_i (clk), .rst_ni (rst_n), .start_i (start), .en_i (en),
        .rsp_i (rsp), .sig_o (sig), .done_o (done), .pass_o (pass)
    );

    // step written from the requirement text (R2)
    function automatic logic [W-1:0] model(input logic [W-1:0] m, input logic [W-1:0] r);
        logic [W-1:0] v;
        logic         fb;
        v  = m ^ LINV;
        fb = v[W-1] ^ FINV;
        return {v[W-2:0], 1'b0} ^ ({W{fb}} & TAPS) ^ r;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic t_reset();
        repeat (2) @(negedge clk);
        chk("R1 sig in reset", sig, SEED);
        chk("R1 done in reset", {7'd0, done}, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 sig after reset", sig, SEED);
        chk("R1 pass after reset", {7'd0, pass}, 8'd0);
        exp_sig = SEED;
    endtask

    task automatic t_idle();
        for (int i = 0; i < 4; i++) begin
            en  = i[0];
            rsp = 8'h5A ^ W'(i * 37);
            @(negedge clk);
            chk("R7 idle holds", sig, exp_sig);
        end
        en = 1'b0;
    endtask

    // one full session; words in w, gaps inserts idle enable cycles
    task automatic t_session(input logic [W-1:0] w [LEN], input bit gaps, input bit stray_start);
        logic pexp;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R8 no reload at start", sig, exp_sig);
        for (int i = 0; i < LEN; i++) begin
            if (gaps && i[0]) begin
                en    = 1'b0;
                rsp   = ~w[i];
                start = stray_start && (i == 1);
                @(negedge clk);
                start = 1'b0;
                chk("R3 hold while en low", sig, exp_sig);
                if (stray_start && i == 1) chk("R7 stray start ignored", sig, exp_sig);
            end
            en  = 1'b1;
            rsp = w[i];
            @(negedge clk);
            exp_sig = model(exp_sig, w[i]);
            chk("R2 step", sig, exp_sig);
            chk("R4 no early done", {7'd0, done}, 8'd0);
        end
        en  = 1'b0;
        rsp = 8'hFF;
        @(negedge clk);
        exp_sig = model(exp_sig, '0);
        chk("R5 padding step", sig, exp_sig);
        chk("R4 done pulse", {7'd0, done}, 8'd1);
        pexp = (exp_sig == GOLDEN);
        chk("R6 pass at done", {7'd0, pass}, {7'd0, pexp});
        @(negedge clk);
        chk("R4 done one cycle", {7'd0, done}, 8'd0);
        chk("R6 pass held", {7'd0, pass}, {7'd0, pexp});
        chk("R7 hold after session", sig, exp_sig);
    endtask

    // choose the last word so the run ends on GOLDEN (R6)
    task automatic t_pass_session();
        logic [W-1:0] w [LEN];
        logic [W-1:0] m, x;
        m = exp_sig;
        for (int i = 0; i < LEN - 1; i++) begin
            w[i] = 8'h91 ^ W'(i * 29);
            m    = model(m, w[i]);
        end
        x = '0;
        for (int c = 0; c < (1 << W); c++) begin
            if (model(W'(c), '0) == GOLDEN) x = W'(c);
        end
        w[LEN-1] = x ^ model(m, '0);
        t_session(w, 1'b0, 1'b0);
        chk("R6 passing run signature", sig, GOLDEN);
        chk("R6 pass set", {7'd0, pass}, 8'd1);
    endtask

    initial begin
        logic [W-1:0] wa [LEN];
        for (int i = 0; i < LEN; i++) wa[i] = 8'h3C ^ W'(i * 71);
        t_reset();
        t_idle();
        t_session(wa, 1'b0, 1'b0);
        t_idle();
        for (int i = 0; i < LEN; i++) wa[i] = 8'hC3 + W'(i * 13);
        t_session(wa, 1'b1, 1'b1);
        t_pass_session();
        t_pass_session();
        for (int i = 0; i < LEN; i++) wa[i] = W'(1 << i);
        t_session(wa, 1'b1, 1'b0);
        if (!ended) begin
            ended = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule